// File: doc/BRIEF.md
# Watchdog Timer with Two-Step Clear

This block is a free-running watchdog. Once enabled it counts ticks. If software does not service it before the count runs out, it asks for a chip reset, or it asks for a wake-up when the device is asleep. Ticks come from one of two sources, chosen by a configuration bit:

- the system clock divided by a power-of-two prescaler;
- an external real-time tick that arrives as a one-cycle strobe already in the `clk` domain.

Instruction decode services the watchdog through three one-cycle strobes: `clr_single`, `clr_part_a` and `clr_part_b`. In one-step mode any one of the three restarts the count. In two-step mode only the pair of partial strobes restarts it. The pair may come in either order or in the same cycle, and `clr_single` is then ignored.

A small sequencer with three states tracks the two-step mode:

- `SEQ_IDLE` means no part is pending.
- `SEQ_HOLD_A` means part A was seen and part B is awaited.
- `SEQ_HOLD_B` means part B was seen and part A is awaited.

The named transitions are:

- *arm_a*: `SEQ_IDLE` to `SEQ_HOLD_A` on A alone.
- *arm_b*: `SEQ_IDLE` to `SEQ_HOLD_B` on B alone.
- *pair_now*: A and B together in `SEQ_IDLE`. A restart is issued and the state stays `SEQ_IDLE`.
- *complete_a*: `SEQ_HOLD_B` to `SEQ_IDLE` on A, with a restart.
- *complete_b*: `SEQ_HOLD_A` to `SEQ_IDLE` on B, with a restart.
- *drop*: any state to `SEQ_IDLE` on expiry, on reset, or whenever one-step mode is selected.

Two status flags are kept. `to_flag` records an expiry. `pdf_flag` records entry into power-down and is set by `halt_cmd`. Every restart clears both flags.

Top module: `wdt_guard`

## Requirements
- R1: While `rst_n` is low, `rst_req`, `wake_req`, `to_flag` and `pdf_flag` are 0, and both pending clear parts are dropped.
- R2: With `cfg_src_rtc`=0, expiry happens 2^(PRESC_W+CNT_W) clock edges after the edge of the last restart. With the defaults PRESC_W=4 and CNT_W=4 this is 256 edges.
- R3: With `cfg_src_rtc`=1, the counter advances only on `rtc_tick`. Expiry happens on the edge that samples the 2^CNT_W-th tick after the restart, which is the 16th tick with the defaults.
- R4: With `cfg_dual_clear`=0, any one of `clr_single`, `clr_part_a` or `clr_part_b` restarts the count and the prescaler.
- R5: With `cfg_dual_clear`=1, a restart needs both `clr_part_a` and `clr_part_b`, in either order or in one cycle. `clr_single` alone, or a repeat of the part already pending, does not restart.
- R6: An expiry drops any pending part, so a later lone partial strobe does not restart.
- R7: A restart clears `to_flag` and `pdf_flag`. `halt_cmd` sets `pdf_flag`.
- R8: An expiry while `sleeping`=0 gives a one-cycle `rst_req` pulse on the edge of expiry and sets `to_flag`.
- R9: An expiry while `sleeping`=1 gives a one-cycle `wake_req` pulse, no `rst_req`, and sets `to_flag`.
- R10: While `cfg_enable`=0 the counter and prescaler stay at zero and nothing expires. After re-enabling, expiry comes a full period (R2) after the last disabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | 1 enables the watchdog |
| cfg_src_rtc | input | 1 | Tick source: 0 divided system clock, 1 `rtc_tick` |
| cfg_dual_clear | input | 1 | 1 requires the two-part clear |
| rtc_tick | input | 1 | One-cycle real-time tick strobe |
| sleeping | input | 1 | Device is halted; expiry wakes instead of resetting |
| halt_cmd | input | 1 | Halt instruction strobe, sets `pdf_flag` |
| clr_single | input | 1 | Single clear strobe |
| clr_part_a | input | 1 | First partial clear strobe |
| clr_part_b | input | 1 | Second partial clear strobe |
| rst_req | output | 1 | One-cycle chip reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| to_flag | output | 1 | Time-out status flag |
| pdf_flag | output | 1 | Power-down status flag |

## Verification
The embedded assertions check on every cycle the following:

- `rst_req` and `wake_req` never coincide.
- Each pulse is backed by a set `to_flag`, and a wake pulse follows a sleeping cycle.
- A restart leaves both flags clear.
- The counter wraps after an expiry and is held at zero while disabled.
- An expiry returns the sequencer to `SEQ_IDLE`.
- A lone single strobe in two-step mode never restarts.

The exact period in both tick modes needs the bench's scenarios, as do the either-order pairing and the loss of a pending part across an expiry. These are seen only as the timing of later pulses, which the bench's scoreboard predicts edge by edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Two-step clear sequencer states
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_HOLD_A = 2'd1,
        SEQ_HOLD_B = 2'd2
    } seq_state_e;

    // Tick source selection
    typedef enum logic {
        SRC_SYSDIV = 1'b0,
        SRC_RTC    = 1'b1
    } tick_src_e;

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int PRESC_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic src_rtc,
    input  logic rtc_tick,
    input  logic restart,
    output logic tick
);
    import wdt_pkg::*;

    logic      sys_tick;
    tick_src_e src;

    generate
        if (PRESC_W == 0) begin : g_nodiv
            assign sys_tick = 1'b1;
        end else begin : g_div
            localparam logic [PRESC_W-1:0] DIV_TOP = '1;
            logic [PRESC_W-1:0] div_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    div_q <= '0;
                else if (!enable || restart)
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end

            assign sys_tick = (div_q == DIV_TOP);

            // R10: prescaler stays at zero while disabled
            a_r10_div_idle: assert property (@(posedge clk) disable iff (!rst_n)
                !enable |=> div_q == '0);
        end
    endgenerate

    assign src = tick_src_e'(src_rtc);

    always_comb begin
        unique case (src)
            SRC_SYSDIV: tick = enable && sys_tick;
            SRC_RTC:    tick = enable && rtc_tick;
            default:    tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic clear,
    output logic expire
);
    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    logic [CNT_W-1:0] cnt_q;

    assign expire = enable && tick && !clear && (cnt_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear || !enable)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // R2: the count wraps to zero on the edge of expiry
    a_r2_wrap_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> cnt_q == '0);

    // R10: counter held at zero while disabled
    a_r10_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> cnt_q == '0);

    // R4: a restart leaves the counter at zero
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> cnt_q == '0);

endmodule

// File: rtl/wdt_clear_seq.sv
module wdt_clear_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic dual_mode,
    input  logic clr_single,
    input  logic clr_a,
    input  logic clr_b,
    input  logic expire,
    output logic clear_go
);
    import wdt_pkg::*;

    seq_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SEQ_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!dual_mode) begin
            state_d = SEQ_IDLE;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (clr_a && !clr_b)      state_d = SEQ_HOLD_A;   // arm_a
                    else if (clr_b && !clr_a) state_d = SEQ_HOLD_B;   // arm_b
                end
                SEQ_HOLD_A: if (clr_b) state_d = SEQ_IDLE;            // complete_b
                SEQ_HOLD_B: if (clr_a) state_d = SEQ_IDLE;            // complete_a
                default:    state_d = SEQ_IDLE;
            endcase
        end
        if (expire) state_d = SEQ_IDLE;                               // drop
    end

    // Outputs
    always_comb begin
        clear_go = 1'b0;
        if (!dual_mode) begin
            clear_go = clr_single || clr_a || clr_b;
        end else begin
            unique case (state_q)
                SEQ_IDLE:   clear_go = clr_a && clr_b;                // pair_now
                SEQ_HOLD_A: clear_go = clr_b;
                SEQ_HOLD_B: clear_go = clr_a;
                default:    clear_go = 1'b0;
            endcase
        end
    end

    // R6: expiry drops any pending part
    a_r6_expire_drops: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> state_q == SEQ_IDLE);

    // R5: a lone single strobe never restarts in two-step mode
    a_r5_single_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_mode && clr_single && !clr_a && !clr_b) |-> !clear_go);

    // R5: a restart in two-step mode always returns to idle
    a_r5_pair_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_mode && clear_go) |=> state_q == SEQ_IDLE);

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
    parameter int PRESC_W = 4,
    parameter int CNT_W   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_enable,
    input  logic cfg_src_rtc,
    input  logic cfg_dual_clear,
    input  logic rtc_tick,
    input  logic sleeping,
    input  logic halt_cmd,
    input  logic clr_single,
    input  logic clr_part_a,
    input  logic clr_part_b,
    output logic rst_req,
    output logic wake_req,
    output logic to_flag,
    output logic pdf_flag
);
    logic clear_go;
    logic tick;
    logic expire;

    wdt_clear_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dual_mode  (cfg_dual_clear),
        .clr_single (clr_single),
        .clr_a      (clr_part_a),
        .clr_b      (clr_part_b),
        .expire     (expire),
        .clear_go   (clear_go)
    );

    wdt_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (cfg_enable),
        .src_rtc  (cfg_src_rtc),
        .rtc_tick (rtc_tick),
        .restart  (clear_go),
        .tick     (tick)
    );

    wdt_count #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (cfg_enable),
        .tick   (tick),
        .clear  (clear_go),
        .expire (expire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req  <= 1'b0;
            wake_req <= 1'b0;
            to_flag  <= 1'b0;
            pdf_flag <= 1'b0;
        end else begin
            rst_req  <= expire && !sleeping;
            wake_req <= expire && sleeping;
            if (clear_go)     to_flag <= 1'b0;
            else if (expire)  to_flag <= 1'b1;
            if (clear_go)      pdf_flag <= 1'b0;
            else if (halt_cmd) pdf_flag <= 1'b1;
        end
    end

    // R9: reset and wake requests are exclusive
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && wake_req));

    // R9: a wake request follows a sleeping cycle
    a_r9_wake_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(sleeping));

    // R8: every request is backed by the time-out flag
    a_r8_req_sets_to: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || wake_req) |-> to_flag);

    // R7: a restart leaves both flags clear
    a_r7_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
        clear_go |=> (!to_flag && !pdf_flag));

endmodule

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int PW   = 4;
    localparam int CW   = 4;
    localparam int PER  = 1 << (PW + CW);
    localparam int NRTC = 1 << CW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b0, cfg_src_rtc = 1'b0, cfg_dual_clear = 1'b0;
    logic rtc_tick = 1'b0, sleeping = 1'b0, halt_cmd = 1'b0;
    logic clr_single = 1'b0, clr_part_a = 1'b0, clr_part_b = 1'b0;
    logic rst_req, wake_req, to_flag, pdf_flag;

    typedef struct {
        int unsigned at;
        bit          wake;
        int          req;
    } exp_t;

    exp_t        q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    int unsigned cyc = 0;
    int unsigned e, t, d;

    wdt_guard #(.PRESC_W(PW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_src_rtc(cfg_src_rtc),
        .cfg_dual_clear(cfg_dual_clear), .rtc_tick(rtc_tick), .sleeping(sleeping),
        .halt_cmd(halt_cmd), .clr_single(clr_single), .clr_part_a(clr_part_a),
        .clr_part_b(clr_part_b), .rst_req(rst_req), .wake_req(wake_req),
        .to_flag(to_flag), .pdf_flag(pdf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops an expected pulse for every observed request
    always @(negedge clk) begin : monitor
        exp_t x;
        if (rst_n && (rst_req || wake_req)) begin
            n_cmp++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL R8 unexpected pulse cycle=%0d rst=%0b wake=%0b expected none",
                         cyc, rst_req, wake_req);
            end else begin
                x = q.pop_front();
                if (x.at != cyc || wake_req != x.wake || rst_req == x.wake) begin
                    n_bad++;
                    $display("FAIL R%0d pulse actual cycle=%0d wake=%0b expected cycle=%0d wake=%0b",
                             x.req, cyc, wake_req, x.at, x.wake);
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic expect_pulse(input int unsigned at, input bit wake, input int req);
        exp_t x;
        x.at = at; x.wake = wake; x.req = req;
        q.push_back(x);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_until(input int unsigned at);
        while (cyc < at) @(negedge clk);
    endtask

    // kind: 0 single, 1 part A, 2 part B, 3 both parts
    task automatic strobe(input int kind, output int unsigned edge_no);
        @(negedge clk);
        case (kind)
            0:       clr_single = 1'b1;
            1:       clr_part_a = 1'b1;
            2:       clr_part_b = 1'b1;
            default: begin clr_part_a = 1'b1; clr_part_b = 1'b1; end
        endcase
        @(posedge clk);
        #1;
        clr_single = 1'b0; clr_part_a = 1'b0; clr_part_b = 1'b0;
        edge_no = cyc;
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin : driver
        // R1: reset state
        cycles(5);
        chk("R1 rst_req", int'(rst_req), 0);
        chk("R1 wake_req", int'(wake_req), 0);
        chk("R1 to_flag", int'(to_flag), 0);
        chk("R1 pdf_flag", int'(pdf_flag), 0);
        @(negedge clk) rst_n = 1'b1;
        cycles(3);

        // R2 / R8: period from enable, reset request
        @(negedge clk);
        cfg_enable = 1'b1;
        d = cyc;
        expect_pulse(d + PER, 1'b0, 2);
        cycles(PER + 5);
        chk("R2 sysdiv period pending", q.size(), 0);
        chk("R8 to_flag after reset request", int'(to_flag), 1);

        // R7: halt sets pdf, clear drops both flags
        @(negedge clk) halt_cmd = 1'b1;
        @(posedge clk); #1 halt_cmd = 1'b0;
        @(negedge clk);
        chk("R7 pdf_flag set by halt_cmd", int'(pdf_flag), 1);
        strobe(0, e);
        @(negedge clk);
        chk("R7 to_flag cleared", int'(to_flag), 0);
        chk("R7 pdf_flag cleared", int'(pdf_flag), 0);

        // R4: each strobe restarts in one-step mode
        cycles(100); strobe(1, e);
        cycles(100); strobe(2, e);
        cycles(100); strobe(0, e);
        expect_pulse(e + PER, 1'b0, 4);
        wait_until(e + PER + 5);
        chk("R4 any strobe restarts", q.size(), 0);

        // R5: two-step mode, single and repeated part ignored
        @(negedge clk) cfg_dual_clear = 1'b1;
        strobe(3, e);
        expect_pulse(e + PER, 1'b0, 5);
        cycles(50); strobe(0, t);
        cycles(50); strobe(1, t);
        cycles(50); strobe(1, t);
        wait_until(e + PER + 5);
        chk("R5 single and repeated part ignored", q.size(), 0);

        // R6: pending part A dropped by expiry; lone B does not restart
        t = e + PER;
        strobe(2, d);
        expect_pulse(t + PER, 1'b0, 6);
        wait_until(t + PER + 5);
        chk("R6 pending dropped on expiry", q.size(), 0);

        // R5: reverse order B then A restarts
        strobe(2, d);
        cycles(20);
        strobe(1, e);
        expect_pulse(e + PER, 1'b0, 5);
        wait_until(e + PER + 5);
        chk("R5 reverse order pair restarts", q.size(), 0);

        // R9: expiry while sleeping wakes
        @(negedge clk) sleeping = 1'b1;
        strobe(3, e);
        expect_pulse(e + PER, 1'b1, 9);
        wait_until(e + PER + 5);
        chk("R9 wake pending", q.size(), 0);
        chk("R9 to_flag after wake", int'(to_flag), 1);
        @(negedge clk) sleeping = 1'b0;

        // R3: real-time tick source
        @(negedge clk);
        cfg_src_rtc = 1'b1;
        cfg_dual_clear = 1'b0;
        strobe(0, e);
        for (int i = 1; i <= NRTC; i++) begin
            @(negedge clk);
            rtc_tick = 1'b1;
            if (i == NRTC) expect_pulse(cyc + 1, 1'b0, 3);
            @(posedge clk); #1 rtc_tick = 1'b0;
            cycles(2);
        end
        cycles(3);
        chk("R3 rtc tick count", q.size(), 0);

        // R10: disabled holds, then restarts from zero
        @(negedge clk);
        cfg_enable = 1'b0;
        cfg_src_rtc = 1'b0;
        cycles(3 * PER);
        chk("R10 no pulse while disabled", q.size(), 0);
        @(negedge clk);
        cfg_enable = 1'b1;
        d = cyc;
        expect_pulse(d + PER, 1'b0, 10);
        wait_until(d + PER + 5);
        chk("R10 period after re-enable", q.size(), 0);

        @(negedge clk) cfg_enable = 1'b0;
        cycles(3);
        finish_run();
    end
endmodule